// File: doc/BRIEF.md
# Presence-Detect Serial EEPROM Core with Lower-Half Write Protection

This block is the digital core of a two-wire (I2C) slave memory of 256 bytes, the kind placed on a memory module so the host can read the module's configuration. It watches the bus clock and data lines in its own system clock domain, finds START and STOP conditions, and decodes the select byte. It then serves byte writes, page writes of up to 16 bytes, random reads, current-address reads and sequential reads from a behavioural register array. The data line is driven open-drain through a single pull-low enable.

A second select type (high nibble `0110`) handles protection commands for the lower 128 bytes. A reversible set or clear needs the high-voltage qualifier input to be asserted. A permanent lock needs the qualifier low and the chip bits equal to the straps. After the lock, every select with that type is refused until reset. A write-control input blocks all data stores. After a STOP that ends a write, a self-timed busy period of `WR_CYCLES` clocks begins. During that period the block refuses every select byte, so the host can poll with select bytes until one is acknowledged.

Top module: `spd_eeprom`

## Requirements
- R1: A select byte with high nibble `1010` and bits 3..1 equal to `strap_i` is acknowledged (SDA pulled low in the 9th clock). Any other chip bits, or an unknown type, get no acknowledge. Bit 0 of the select byte is the direction, where 1 means read.
- R2: In a write, the byte after the select sets the address pointer, and each following data byte is stored and acknowledged. After each stored byte only pointer bits 3..0 increment, so a page write wraps inside its 16-byte page.
- R3: A read returns the byte at the pointer, with the pointer advancing by one over all 8 bits after each byte, rolling from FFh to 00h. A read issued straight after START uses the current pointer. A read after a write-select and an address byte starts at that address.
- R4: When the master leaves SDA high in the acknowledge slot of a read byte, the block releases SDA and drives nothing more until the next START.
- R5: While `wc_i` is high, every data byte gets no acknowledge and the array is left unchanged.
- R6: While protection is on, a data byte aimed at addresses 00h..7Fh gets no acknowledge and the location is unchanged. Addresses 80h..FFh stay writable.
- R7: With `hv_i` high, a protection select with bits 3..1 = `001` sets protection and one with `011` clears it. Each acts at the STOP that follows at least one further acknowledged byte.
- R8: With `hv_i` low, a protection select whose bits 3..1 equal `strap_i` locks protection permanently. After the lock, no select with high nibble `0110` is acknowledged again, and protection stays on until reset.
- R9: A STOP that ends a write with at least one stored byte, or a protection command, starts a busy period of `WR_CYCLES` clocks. During that period every select byte gets no acknowledge, and selects are acknowledged again once it ends.
- R10: Set and clear protection selects sent with `hv_i` low get no acknowledge and leave protection unchanged.
- R11: After reset the block does not drive SDA, protection is off and unlocked, the pointer is 00h and the array holds zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND result) |
| sda_oe | output | 1 | Pull data line low when 1 |
| strap_i | input | 3 | Chip-enable straps compared with select bits 3..1 |
| wc_i | input | 1 | Write control; high blocks all data stores |
| hv_i | input | 1 | High-voltage qualifier for reversible protection commands |

## Verification
Both bus lines pass two synchronizer flops and one edge-detect flop. An acknowledge or read data bit therefore appears on SDA three system clocks after the SCL falling edge that precedes it. The bench changes SDA a quarter bit (6 clocks) after each falling edge, and it samples SDA in the middle of the SCL high phase, well after that delay. The busy period runs `WR_CYCLES` clocks from STOP detection. The bench polls with write selects and requires the first poll to be refused. It also requires the first accepted poll to fall between `WR_CYCLES` and `WR_CYCLES` plus two poll lengths after the STOP.

// File: rtl/spd_pkg.sv
// Shared constants and types for the presence-detect EEPROM core.
// Assumes 8-bit bus bytes and a single address byte (256 locations).
package spd_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W;

    localparam logic [3:0] TYPE_MEM  = 4'b1010;
    localparam logic [3:0] TYPE_PROT = 4'b0110;
    localparam logic [2:0] CODE_SET  = 3'b001;
    localparam logic [2:0] CODE_CLR  = 3'b011;

    typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_RACK} link_st_t;
    typedef enum logic [1:0] {K_SEL, K_ADDR, K_WDATA, K_PROT} rx_kind_t;
    typedef enum logic [1:0] {OP_NONE, OP_SET, OP_CLR, OP_LOCK} prot_op_t;
endpackage

// File: rtl/spd_bus_cond.sv
// Bus condition detector: synchronizes SCL/SDA into clk and flags SCL
// edges, START and STOP. Assumes the bus bit rate is far below clk.
module spd_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] scl_sync, sda_sync;
    logic       scl_p, sda_p;

    // Two-flop synchronizers followed by one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= 2'b11;
            sda_sync <= 2'b11;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[0], scl_i};
            sda_sync <= {sda_sync[0], sda_i};
            scl_p    <= scl_sync[1];
            sda_p    <= sda_sync[1];
        end
    end

    // Edge and condition decode on the synchronized levels.
    always_comb begin
        sda_s     = sda_sync[1];
        scl_rise  = scl_sync[1] & ~scl_p;
        scl_fall  = ~scl_sync[1] & scl_p;
        start_det = scl_sync[1] & scl_p & sda_p & ~sda_sync[1];
        stop_det  = scl_sync[1] & scl_p & ~sda_p & sda_sync[1];
    end
endmodule

// File: rtl/spd_wr_timer.sv
// Self-timed write model: a down-counter loaded at STOP, busy while nonzero.
module spd_wr_timer #(
    parameter int WR_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(WR_CYCLES + 1);
    logic [CW-1:0] cnt;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start_i)    cnt <= CW'(WR_CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy_o = (cnt != '0);

    a_r9_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0 && !start_i) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/spd_wp_ctrl.sv
// Protection state for the lower half: reversible flag plus sticky lock.
// Assumes commands arrive only as one-cycle strobes at STOP.
module spd_wp_ctrl
    import spd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     op_valid_i,
    input  prot_op_t op_i,
    output logic     wp_on_o,
    output logic     locked_o
);
    // Apply a committed command; the lock cannot be undone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_on_o  <= 1'b0;
            locked_o <= 1'b0;
        end else if (op_valid_i) begin
            case (op_i)
                OP_SET:  wp_on_o <= 1'b1;
                OP_CLR:  if (!locked_o) wp_on_o <= 1'b0;
                OP_LOCK: begin
                    wp_on_o  <= 1'b1;
                    locked_o <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> (locked_o && wp_on_o));
endmodule

// File: rtl/spd_mem.sv
// Behavioural byte array, one write port and one asynchronous read port.
// Cleared by reset to model a blank part at power-on.
module spd_mem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] cells [DEPTH];

    // Store one byte per accepted data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we_i) begin
            cells[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/spd_eeprom.sv
// Top of the presence-detect EEPROM core. Runs the bus byte engine
// (receive, acknowledge, transmit, master-acknowledge) and decodes select,
// address, data and protection bytes. Assumes scl_i/sda_i are the bus
// levels and sda_oe pulls the open-drain data line low.
module spd_eeprom
    import spd_pkg::*;
#(
    parameter int PAGE_W    = 4,
    parameter int WR_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] strap_i,
    input  logic       wc_i,
    input  logic       hv_i
);
    localparam logic [ADDR_W-1:0] ADDR_ONE = 1;
    localparam logic [PAGE_W-1:0] PAGE_ONE = 1;

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic busy, wp_on, locked;

    link_st_t          state;
    rx_kind_t          kind;
    prot_op_t          prot_op, sel_op;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] sr, tx_sr, rdata;
    logic [ADDR_W-1:0] addr, page_next;
    logic              rd_mode, wr_pend, prot_arm;
    logic              sel_mem, prot_try, rx_ack, byte_done, mem_we;

    spd_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    spd_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .start_i(stop_det & (wr_pend | prot_arm)), .busy_o(busy)
    );

    spd_wp_ctrl u_wp (
        .clk(clk), .rst_n(rst_n),
        .op_valid_i(stop_det & prot_arm), .op_i(prot_op),
        .wp_on_o(wp_on), .locked_o(locked)
    );

    spd_mem #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we_i(mem_we), .waddr_i(addr),
        .wdata_i(sr), .raddr_i(addr), .rdata_o(rdata)
    );

    // Select decode: memory access or a protection command.
    always_comb begin
        sel_mem  = (sr[7:4] == TYPE_MEM) && (sr[3:1] == strap_i);
        prot_try = (sr[7:4] == TYPE_PROT) && !sr[0] && !locked;
        sel_op   = OP_NONE;
        if (prot_try) begin
            if (hv_i) begin
                if (sr[3:1] == CODE_SET)      sel_op = OP_SET;
                else if (sr[3:1] == CODE_CLR) sel_op = OP_CLR;
            end else if (sr[3:1] == strap_i) begin
                sel_op = OP_LOCK;
            end
        end
    end

    // Acknowledge decision for the byte just received.
    always_comb begin
        case (kind)
            K_SEL:   rx_ack = !busy && (sel_mem || sel_op != OP_NONE);
            K_WDATA: rx_ack = !wc_i && !(wp_on && !addr[ADDR_W-1]);
            default: rx_ack = 1'b1;
        endcase
        byte_done = (state == ST_RX) && scl_fall && (bit_cnt == 4'd8);
        mem_we    = byte_done && (kind == K_WDATA) && rx_ack;
        page_next = {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + PAGE_ONE};
    end

    // Bus byte engine: bit shifting, acknowledge slots and read transmit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            kind     <= K_SEL;
            bit_cnt  <= '0;
            sr       <= '0;
            tx_sr    <= '0;
            sda_oe   <= 1'b0;
            addr     <= '0;
            rd_mode  <= 1'b0;
            wr_pend  <= 1'b0;
            prot_arm <= 1'b0;
            prot_op  <= OP_NONE;
        end else if (start_det) begin
            state    <= ST_RX;
            kind     <= K_SEL;
            bit_cnt  <= '0;
            sda_oe   <= 1'b0;
            rd_mode  <= 1'b0;
            prot_arm <= 1'b0;
        end else if (stop_det) begin
            state    <= ST_IDLE;
            sda_oe   <= 1'b0;
            wr_pend  <= 1'b0;
            prot_arm <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise && bit_cnt < 4'd8) begin
                        sr      <= {sr[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_done) begin
                        bit_cnt <= '0;
                        if (rx_ack) begin
                            sda_oe <= 1'b1;
                            state  <= ST_ACK;
                            case (kind)
                                K_SEL: begin
                                    rd_mode <= sel_mem & sr[0];
                                    prot_op <= sel_op;
                                    kind    <= sel_mem ? K_ADDR : K_PROT;
                                end
                                K_ADDR: begin
                                    addr <= sr;
                                    kind <= K_WDATA;
                                end
                                K_WDATA: begin
                                    addr    <= page_next;
                                    wr_pend <= 1'b1;
                                end
                                default: prot_arm <= 1'b1;
                            endcase
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (rd_mode) begin
                            sda_oe  <= ~rdata[BYTE_W-1];
                            tx_sr   <= {rdata[BYTE_W-2:0], 1'b0};
                            addr    <= addr + ADDR_ONE;
                            bit_cnt <= 4'd1;
                            state   <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bit_cnt < 4'd8) begin
                            sda_oe  <= ~tx_sr[BYTE_W-1];
                            tx_sr   <= {tx_sr[BYTE_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            state   <= ST_RACK;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise && sda_s) begin
                        state <= ST_IDLE;
                    end else if (scl_fall) begin
                        sda_oe  <= ~rdata[BYTE_W-1];
                        tx_sr   <= {rdata[BYTE_W-2:0], 1'b0};
                        addr    <= addr + ADDR_ONE;
                        bit_cnt <= 4'd1;
                        state   <= ST_TX;
                    end
                end
                default: ;
            endcase
        end
    end

    a_r1_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));
    a_r4_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);
    a_r5_wc_blocks_store: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !wc_i);
    a_r2_page_bound: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])));
    a_r9_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && kind == K_SEL && busy) |=> (state == ST_IDLE));
endmodule

// File: tb/tb_spd_eeprom.sv
module tb_spd_eeprom;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int WR_T       = 1000;
    localparam int POLL_LEN   = 43 * Q;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic wc = 1'b0, hv = 1'b0;
    logic sda_oe;
    logic sda_line;
    assign sda_line = sda_m & ~sda_oe;

    int vectors = 0, errs = 0, cyc = 0, t_stop = 0;
    bit done = 0;

    logic [7:0] m_mem [256];
    logic [7:0] m_ptr = '0;
    bit m_wp = 0, m_lock = 0;

    spd_eeprom #(.PAGE_W(4), .WR_CYCLES(WR_T)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_i(STRAP), .wc_i(wc), .hv_i(hv)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_store(input logic [7:0] a, input bit wcv);
        return !wcv && !(m_wp && !a[7]);
    endfunction

    function automatic bit exp_prot(input logic [2:0] code, input bit hvv);
        if (m_lock) return 0;
        if (hvv) return (code == 3'b001) || (code == 3'b011);
        return code == STRAP;
    endfunction

    task automatic bus_start;
        sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
        t_stop = cyc;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
        end
        sda_m = 1; tick(Q); scl_m = 1; tick(Q);
        ack = (sda_line == 1'b0);
        tick(Q); scl_m = 0; tick(Q);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1; tick(Q); scl_m = 1; tick(Q);
            b[i] = sda_line;
            tick(Q); scl_m = 0; tick(Q);
        end
        sda_m = mack ? 1'b0 : 1'b1; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
        sda_m = 1;
    endtask

    // R9: poll with write selects until accepted, checking the window.
    task automatic wait_busy;
        bit ack, got;
        int t0, el;
        got = 0; el = 0; t0 = t_stop;
        for (int p = 0; p < 40 && !got; p++) begin
            bus_start;
            send_byte({4'b1010, STRAP, 1'b0}, ack);
            el = cyc - t0;
            if (p == 0) chk(!ack, "R9 first poll refused", ack, 0);
            if (ack) got = 1;
            bus_stop;
        end
        chk(got && el >= WR_T && el <= WR_T + 2*POLL_LEN, "R9 busy window", el, WR_T);
    endtask

    task automatic do_write(input logic [7:0] a, input int n, input bit wcv);
        bit ack, ok;
        int nw;
        logic [7:0] d, p;
        wc = wcv; nw = 0;
        bus_start;
        send_byte({4'b1010, STRAP, 1'b0}, ack);
        chk(ack, "R1 write select", ack, 1);
        send_byte(a, ack);
        chk(ack, "R2 address byte", ack, 1);
        p = a;
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            ok = exp_store(p, wcv);
            send_byte(d, ack);
            if (wcv)              chk(ack == ok, "R5 wc data ack", ack, ok);
            else if (m_wp && !p[7]) chk(ack == ok, "R6 protected data ack", ack, ok);
            else                  chk(ack == ok, "R2 data ack", ack, ok);
            if (!ok) break;
            m_mem[p] = d; nw++;
            p = {p[7:4], p[3:0] + 4'd1};
        end
        bus_stop;
        wc = 0; m_ptr = p;
        if (nw > 0) wait_busy;
    endtask

    task automatic do_read(input bit random, input logic [7:0] a, input int n, input string req);
        bit ack;
        logic [7:0] d;
        if (random) begin
            bus_start;
            send_byte({4'b1010, STRAP, 1'b0}, ack);
            chk(ack, "R1 select before read", ack, 1);
            send_byte(a, ack);
            chk(ack, "R3 read address", ack, 1);
            m_ptr = a;
        end
        bus_start;
        send_byte({4'b1010, STRAP, 1'b1}, ack);
        chk(ack, "R1 read select", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            chk(d == m_mem[m_ptr], req, d, m_mem[m_ptr]);
            m_ptr = m_ptr + 8'd1;
        end
        bus_stop;
    endtask

    task automatic prot_cmd(input logic [2:0] code, input bit hvv, input string req);
        bit ack, e, a2;
        e = exp_prot(code, hvv);
        hv = hvv;
        bus_start;
        send_byte({4'b0110, code, 1'b0}, ack);
        chk(ack == e, req, ack, e);
        if (ack) begin
            send_byte(8'h00, a2);
            send_byte(8'h00, a2);
        end
        bus_stop;
        hv = 0;
        if (ack && e) begin
            if (!hvv) begin m_lock = 1; m_wp = 1; end
            else if (code == 3'b001) m_wp = 1;
            else m_wp = 0;
            wait_busy;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] d;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) m_mem[i] = '0;
        tick(5);
        rst_n = 1;
        tick(5);

        // R11: reset state
        chk(sda_oe == 1'b0, "R11 no drive after reset", sda_oe, 0);
        do_read(0, 8'h00, 2, "R11 pointer zero and blank array");

        // R1: wrong chip bits and wrong type refused
        bus_start;
        send_byte({4'b1010, STRAP ^ 3'b010, 1'b0}, ack);
        chk(!ack, "R1 chip mismatch", ack, 0);
        bus_stop;
        bus_start;
        send_byte({4'b0011, STRAP, 1'b1}, ack);
        chk(!ack, "R1 unknown type", ack, 0);
        bus_stop;

        // R2/R9: byte write then page write wrapping inside its page
        do_write(8'h90, 1, 0);
        do_write(8'hAC, 8, 0);
        do_read(1, 8'hA0, 16, "R2 page wrap readback");

        // R3: rollover FFh -> 00h, and current-address read
        do_write(8'hFF, 1, 0);
        do_read(1, 8'hFE, 3, "R3 rollover read");
        do_read(0, 8'h00, 2, "R3 current address read");

        // R4: after master NoAck no further drive
        do_read(1, 8'h90, 1, "R4 last byte");
        bus_start;
        send_byte({4'b1010, STRAP, 1'b1}, ack);
        recv_byte(0, d);
        recv_byte(0, d);
        chk(d == 8'hFF, "R4 released after NoAck", d, 8'hFF);
        bus_stop;
        m_ptr = 8'h92;

        // R5: write control blocks stores; nothing stored so no busy
        do_write(8'h90, 2, 1);
        bus_start;
        send_byte({4'b1010, STRAP, 1'b0}, ack);
        chk(ack, "R9 no busy without store", ack, 1);
        bus_stop;
        do_read(1, 8'h90, 2, "R5 array unchanged");

        // R10: reversible commands need the qualifier
        prot_cmd(3'b001, 0, "R10 set without hv");
        prot_cmd(3'b011, 0, "R10 clear without hv");
        do_write(8'h10, 1, 0);

        // R6/R7: set, protected lower half, writable upper half, clear
        prot_cmd(3'b001, 1, "R7 set with hv");
        do_write(8'h10, 2, 0);
        do_write(8'h85, 2, 0);
        do_read(1, 8'h10, 2, "R6 lower half unchanged");
        prot_cmd(3'b011, 1, "R7 clear with hv");
        do_write(8'h10, 2, 0);
        do_read(1, 8'h10, 2, "R7 lower half writable again");

        // Random mixed traffic with protection off
        for (int it = 0; it < 8; it++) begin
            int op;
            op = $urandom % 3;
            if (op == 0)      do_write(8'($urandom), 1 + $urandom % 4, ($urandom % 4) == 0);
            else if (op == 1) do_read(1, 8'($urandom), 1 + $urandom % 3, "R3 random read");
            else              do_read(0, 8'h00, 1 + $urandom % 2, "R3 random current read");
        end

        // R8: permanent lock, then the protection type is refused
        prot_cmd(STRAP, 0, "R8 lock accepted");
        prot_cmd(3'b011, 1, "R8 clear refused after lock");
        prot_cmd(3'b001, 1, "R8 set refused after lock");
        wc = 1;
        prot_cmd(STRAP, 0, "R8 lock refused with wc high");
        wc = 0;
        do_write(8'h20, 1, 0);
        do_read(1, 8'h20, 1, "R8 lower half still protected");

        // Random mixed traffic with the lock in place
        for (int it = 0; it < 6; it++) begin
            int op;
            op = $urandom % 2;
            if (op == 0) do_write(8'($urandom), 1 + $urandom % 3, ($urandom % 4) == 0);
            else         do_read(1, 8'($urandom), 1 + $urandom % 3, "R6 random read under lock");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule